// File: doc/BRIEF.md
# Execute Unit: ALU, Shifter and Jump-Condition Evaluator

This block is the execute stage of a small 32-bit RISC core. From a decoded instruction it takes a 3-bit function selector, a 4-bit operation selector, a 5-bit count and the two register operands. It first combines the operands arithmetically or logically. It then sends that value through a barrel shifter or rotator picked by the operation selector. It returns the shifted value together with the adder carry and a flag that says whether a jump is taken.

The upper half of the operation space (selector values 8 to 15) marks jump forms. For these the ALU value is passed through unchanged, and the jump flag comes from a test on that value or on the carry. All three outputs are registered, so each instruction's result appears one clock after its operands are presented. This gives the core one clean pipeline boundary between execute and write-back.

Top module: `rxu_execute`

## Requirements
- R1: Function 0 returns A+B and function 1 returns A-B, computed as A + ~B + 1. The carry output is the carry out of bit 31 of that sum.
- R2: Function 2 returns A AND B, 3 returns A AND NOT B, 4 returns A OR B, 5 returns A OR NOT B, 6 returns A XOR B and 7 returns A XOR NOT B. For all six the carry output is 0.
- R3: Operation 0 shifts the ALU value right logically, 1 shifts it left logically, 2 rotates it right and 3 rotates it left, each by the count.
- R4: Operation 4 shifts the ALU value right arithmetically by the count, filling with bit 31.
- R5: Operations 5 to 15 pass the ALU value through with no shift, whatever the count.
- R6: A count of 0 leaves the value unchanged for every shift and rotate operation.
- R7: For operations 8 to 15 the jump flag is: 8 always set; 9 set when result bit 31 is 1; 10 set when all 32 result bits are 0; 11 set when the carry is 1; 12 always set; 13 set when result bit 31 is 0; 14 set when any result bit is 1; 15 set when the carry is 0.
- R8: For operations 0 to 7 the jump flag is 0.
- R9: Result, carry and jump flag take the values for the inputs present at a rising clock edge, and hold them until the next edge.
- R10: While the active-high synchronous reset is sampled high at a rising edge, result, carry and jump flag become 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| func_i | input | 3 | ALU function selector |
| op_i | input | 4 | Shift / jump operation selector |
| count_i | input | 5 | Shift or rotate count |
| opa_i | input | 32 | First operand (A) |
| opb_i | input | 32 | Second operand (B) |
| result_o | output | 32 | Registered shifted result |
| carry_o | output | 1 | Registered ALU carry |
| jump_o | output | 1 | Registered jump-taken flag |

## Verification
The bench targets subtraction carry polarity, where equal operands must give carry 1. A design that subtracts without the +1 form would report 0 there and flip the jump forms 11 and 15. It sweeps every count for each shift kind with operands that have bit 31 set. A swapped rotate direction, a logical fill on the arithmetic shift, or a wrong count-0 path would show up as wrong bits at the word ends. It also sets nonzero counts on operations 5 to 15, so that a shifter which wrongly acts on those codes changes the result. Finally it checks that the outputs still hold the previous value just after new inputs arrive, and that a reset in the middle of a run clears a nonzero result.

// File: rtl/rxu_pkg.sv
package rxu_pkg;

  typedef enum logic [2:0] {
    FN_ADD  = 3'd0,
    FN_SUB  = 3'd1,
    FN_AND  = 3'd2,
    FN_ANDN = 3'd3,
    FN_OR   = 3'd4,
    FN_ORN  = 3'd5,
    FN_XOR  = 3'd6,
    FN_XNOR = 3'd7
  } fn_e;

  typedef enum logic [2:0] {
    SK_NONE = 3'd0,
    SK_LSR  = 3'd1,
    SK_LSL  = 3'd2,
    SK_ROR  = 3'd3,
    SK_ROL  = 3'd4,
    SK_ASR  = 3'd5
  } shift_kind_e;

  // jump-form operations occupy the upper half of the op space
  function automatic logic op_is_jump(input logic [3:0] op);
    return op[3];
  endfunction

  function automatic shift_kind_e op_shift_kind(input logic [3:0] op);
    shift_kind_e k;
    case (op)
      4'd0:    k = SK_LSR;
      4'd1:    k = SK_LSL;
      4'd2:    k = SK_ROR;
      4'd3:    k = SK_ROL;
      4'd4:    k = SK_ASR;
      default: k = SK_NONE;
    endcase
    return k;
  endfunction

endpackage

// File: rtl/rxu_alu.sv
module rxu_alu #(
  parameter int W = 32
) (
  input  logic [2:0]   func_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] res_o,
  output logic         carry_o
);
  import rxu_pkg::*;

  // add with explicit carry-in; subtraction feeds ~B and carry-in 1
  function automatic logic [W:0] add_cin(input logic [W-1:0] x,
                                         input logic [W-1:0] y,
                                         input logic         cin);
    return {1'b0, x} + {1'b0, y} + {{W{1'b0}}, cin};
  endfunction

  logic         is_sub;
  logic [W-1:0] b_eff;
  logic [W:0]   sum;
  logic [W-1:0] b_inv;

  assign is_sub = (fn_e'(func_i) == FN_SUB);
  assign b_inv  = ~b_i;
  assign b_eff  = is_sub ? b_inv : b_i;
  assign sum    = add_cin(a_i, b_eff, is_sub);

  always_comb begin
    res_o   = '0;
    carry_o = 1'b0;
    case (fn_e'(func_i))
      FN_ADD, FN_SUB: begin
        res_o   = sum[W-1:0];
        carry_o = sum[W];
      end
      FN_AND:  res_o = a_i & b_i;
      FN_ANDN: res_o = a_i & b_inv;
      FN_OR:   res_o = a_i | b_i;
      FN_ORN:  res_o = a_i | b_inv;
      FN_XOR:  res_o = a_i ^ b_i;
      FN_XNOR: res_o = a_i ^ b_inv;
      default: res_o = '0;
    endcase
  end

endmodule

// File: rtl/rxu_shifter.sv
module rxu_shifter #(
  parameter int W = 32,
  localparam int CW = $clog2(W)
) (
  input  logic [3:0]    op_i,
  input  logic [CW-1:0] count_i,
  input  logic [W-1:0]  val_i,
  output logic [W-1:0]  val_o
);
  import rxu_pkg::*;

  shift_kind_e kind;
  logic        go_left;
  logic        do_rot;
  logic        do_arith;
  logic        active;

  assign kind     = op_shift_kind(op_i);
  assign active   = (kind != SK_NONE);
  assign go_left  = (kind == SK_LSL) || (kind == SK_ROL);
  assign do_rot   = (kind == SK_ROR) || (kind == SK_ROL);
  assign do_arith = (kind == SK_ASR);

  // logarithmic barrel: stage k moves by 2**k when count bit k is set
  logic [W-1:0] stage [CW+1];
  assign stage[0] = val_i;

  for (genvar k = 0; k < CW; k++) begin : g_stage
    localparam int S = 1 << k;
    logic [W-1:0] x;
    logic [S-1:0] fill_r;
    logic [S-1:0] fill_l;
    logic [W-1:0] right_v;
    logic [W-1:0] left_v;

    assign x       = stage[k];
    assign fill_r  = do_rot ? x[S-1:0] : (do_arith ? {S{x[W-1]}} : {S{1'b0}});
    assign fill_l  = do_rot ? x[W-1:W-S] : {S{1'b0}};
    assign right_v = {fill_r, x[W-1:S]};
    assign left_v  = {x[W-1-S:0], fill_l};
    assign stage[k+1] = (active && count_i[k]) ? (go_left ? left_v : right_v) : x;
  end

  assign val_o = stage[CW];

endmodule

// File: rtl/rxu_jump_eval.sv
module rxu_jump_eval #(
  parameter int W = 32
) (
  input  logic [3:0]   op_i,
  input  logic [W-1:0] res_i,
  input  logic         carry_i,
  output logic         take_o
);
  import rxu_pkg::*;

  logic is_neg;
  logic is_zero;
  logic cond;

  assign is_neg  = res_i[W-1];
  assign is_zero = (res_i == '0);

  always_comb begin
    case (op_i[2:0])
      3'd0:    cond = 1'b1;
      3'd1:    cond = is_neg;
      3'd2:    cond = is_zero;
      3'd3:    cond = carry_i;
      3'd4:    cond = 1'b1;
      3'd5:    cond = !is_neg;
      3'd6:    cond = !is_zero;
      default: cond = !carry_i;
    endcase
  end

  assign take_o = op_is_jump(op_i) && cond;

endmodule

// File: rtl/rxu_execute.sv
module rxu_execute #(
  parameter int W = 32,
  localparam int CW = $clog2(W)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [2:0]    func_i,
  input  logic [3:0]    op_i,
  input  logic [CW-1:0] count_i,
  input  logic [W-1:0]  opa_i,
  input  logic [W-1:0]  opb_i,
  output logic [W-1:0]  result_o,
  output logic          carry_o,
  output logic          jump_o
);

  // named internal events, observed by the bound checker
  logic [W-1:0] alu_res;
  logic         alu_cy;
  logic [W-1:0] shf_res;
  logic         jmp_take;

  rxu_alu #(.W(W)) u_alu (
    .func_i  (func_i),
    .a_i     (opa_i),
    .b_i     (opb_i),
    .res_o   (alu_res),
    .carry_o (alu_cy)
  );

  rxu_shifter #(.W(W)) u_shf (
    .op_i    (op_i),
    .count_i (count_i),
    .val_i   (alu_res),
    .val_o   (shf_res)
  );

  rxu_jump_eval #(.W(W)) u_jmp (
    .op_i    (op_i),
    .res_i   (shf_res),
    .carry_i (alu_cy),
    .take_o  (jmp_take)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      result_o <= '0;
      carry_o  <= 1'b0;
      jump_o   <= 1'b0;
    end else begin
      result_o <= shf_res;
      carry_o  <= alu_cy;
      jump_o   <= jmp_take;
    end
  end

endmodule

// File: rtl/rxu_execute_chk.sv
module rxu_execute_chk #(
  parameter int W = 32,
  localparam int CW = $clog2(W)
) (
  input logic          clk,
  input logic          rst,
  input logic [2:0]    func_i,
  input logic [3:0]    op_i,
  input logic [CW-1:0] count_i,
  input logic [W-1:0]  alu_res,
  input logic          alu_cy,
  input logic [W-1:0]  shf_res,
  input logic          jmp_take,
  input logic [W-1:0]  result_o,
  input logic          carry_o,
  input logic          jump_o
);

  AST_LOGIC_NO_CARRY: assert property (@(posedge clk) disable iff (rst)
    (func_i >= 3'd2) |-> !alu_cy); // R2

  AST_ROTATE_KEEPS_ONES: assert property (@(posedge clk) disable iff (rst)
    (op_i == 4'd2 || op_i == 4'd3) |-> ($countones(shf_res) == $countones(alu_res))); // R3

  AST_ASR_KEEPS_SIGN: assert property (@(posedge clk) disable iff (rst)
    (op_i == 4'd4) |-> (shf_res[W-1] == alu_res[W-1])); // R4

  AST_NO_SHIFT_PASS: assert property (@(posedge clk) disable iff (rst)
    (op_i >= 4'd5) |-> (shf_res == alu_res)); // R5

  AST_ZERO_COUNT_PASS: assert property (@(posedge clk) disable iff (rst)
    (count_i == '0) |-> (shf_res == alu_res)); // R6

  AST_NEG_JUMP: assert property (@(posedge clk) disable iff (rst)
    (op_i == 4'd9) |-> (jmp_take == shf_res[W-1])); // R7

  AST_NONJUMP_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (op_i < 4'd8) |-> !jmp_take); // R8

  AST_OUT_REGISTERED: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (result_o == $past(shf_res) && carry_o == $past(alu_cy) && jump_o == $past(jmp_take))); // R9

  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (result_o == '0 && !carry_o && !jump_o)); // R10

endmodule

bind rxu_execute rxu_execute_chk #(.W(W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .func_i   (func_i),
  .op_i     (op_i),
  .count_i  (count_i),
  .alu_res  (alu_res),
  .alu_cy   (alu_cy),
  .shf_res  (shf_res),
  .jmp_take (jmp_take),
  .result_o (result_o),
  .carry_o  (carry_o),
  .jump_o   (jump_o)
);

// File: tb/rxu_execute_bench.sv
module rxu_execute_bench;
  localparam int W = 32;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 21;
  localparam int VW = 3 + 4 + 5 + 32 + 32 + 32 + 1 + 1;

  // {func, op, count, A, B, expected result, expected carry, expected jump}
  localparam logic [VW-1:0] VEC [NV] = '{
    {3'd0, 4'd5,  5'd0, 32'hFFFFFFFF, 32'h00000001, 32'h00000000, 1'b1, 1'b0}, // R1
    {3'd1, 4'd5,  5'd0, 32'h00000005, 32'h00000005, 32'h00000000, 1'b1, 1'b0}, // R1
    {3'd1, 4'd5,  5'd0, 32'h00000000, 32'h00000001, 32'hFFFFFFFF, 1'b0, 1'b0}, // R1
    {3'd3, 4'd5,  5'd0, 32'hF0F0F0F0, 32'hFF000000, 32'h00F0F0F0, 1'b0, 1'b0}, // R2
    {3'd5, 4'd5,  5'd0, 32'h00000000, 32'hFFFF0000, 32'h0000FFFF, 1'b0, 1'b0}, // R2
    {3'd7, 4'd5,  5'd0, 32'h12345678, 32'hFFFFFFFF, 32'h12345678, 1'b0, 1'b0}, // R2
    {3'd4, 4'd0,  5'd4, 32'h80000000, 32'h00000000, 32'h08000000, 1'b0, 1'b0}, // R3
    {3'd4, 4'd1,  5'd4, 32'h80000001, 32'h00000000, 32'h00000010, 1'b0, 1'b0}, // R3
    {3'd4, 4'd2,  5'd4, 32'h0000000F, 32'h00000000, 32'hF0000000, 1'b0, 1'b0}, // R3
    {3'd4, 4'd3,  5'd8, 32'h12345678, 32'h00000000, 32'h34567812, 1'b0, 1'b0}, // R3
    {3'd4, 4'd4,  5'd4, 32'h80000000, 32'h00000000, 32'hF8000000, 1'b0, 1'b0}, // R4
    {3'd0, 4'd6,  5'd7, 32'h00000001, 32'h00000001, 32'h00000002, 1'b0, 1'b0}, // R5
    {3'd4, 4'd0,  5'd0, 32'h80000001, 32'h00000000, 32'h80000001, 1'b0, 1'b0}, // R6
    {3'd1, 4'd10, 5'd0, 32'h00000007, 32'h00000007, 32'h00000000, 1'b1, 1'b1}, // R7
    {3'd0, 4'd9,  5'd3, 32'h7FFFFFFF, 32'h00000001, 32'h80000000, 1'b0, 1'b1}, // R7
    {3'd0, 4'd11, 5'd0, 32'hFFFFFFFF, 32'h00000001, 32'h00000000, 1'b1, 1'b1}, // R7
    {3'd0, 4'd15, 5'd0, 32'hFFFFFFFF, 32'h00000001, 32'h00000000, 1'b1, 1'b0}, // R7
    {3'd1, 4'd13, 5'd0, 32'h00000000, 32'h00000001, 32'hFFFFFFFF, 1'b0, 1'b0}, // R7
    {3'd2, 4'd14, 5'd0, 32'h000000F0, 32'h0000000F, 32'h00000000, 1'b0, 1'b0}, // R7
    {3'd2, 4'd12, 5'd9, 32'h000000F0, 32'h0000000F, 32'h00000000, 1'b0, 1'b1}, // R7
    {3'd4, 4'd8,  5'd0, 32'h00000000, 32'h00000000, 32'h00000000, 1'b0, 1'b1}  // R7
  };

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [2:0]    func_i = '0;
  logic [3:0]    op_i = '0;
  logic [4:0]    count_i = '0;
  logic [W-1:0]  opa_i = '0;
  logic [W-1:0]  opb_i = '0;
  logic [W-1:0]  result_o;
  logic          carry_o;
  logic          jump_o;

  int n_checks = 0;
  int n_fail = 0;
  logic done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rxu_execute u_rxu_execute (
    .clk(clk), .rst(rst), .func_i(func_i), .op_i(op_i), .count_i(count_i),
    .opa_i(opa_i), .opb_i(opb_i), .result_o(result_o), .carry_o(carry_o), .jump_o(jump_o)
  );

  // independent reference: bit-by-bit shifter, widened arithmetic
  function automatic logic [W+1:0] ref_model(input logic [2:0] f, input logic [3:0] op,
                                             input logic [4:0] c, input logic [W-1:0] a,
                                             input logic [W-1:0] b);
    logic [W:0]   wide;
    logic [W-1:0] v, s;
    logic         cy, jp;
    wide = '0;
    cy = 1'b0;
    case (f)
      3'd0: begin wide = {1'b0, a} + {1'b0, b}; v = wide[W-1:0]; cy = wide[W]; end
      3'd1: begin wide = {1'b0, a} + {1'b0, ~b} + 1; v = wide[W-1:0]; cy = wide[W]; end
      3'd2: v = a & b;
      3'd3: v = a & ~b;
      3'd4: v = a | b;
      3'd5: v = a | ~b;
      3'd6: v = a ^ b;
      default: v = ~(a ^ b);
    endcase
    for (int i = 0; i < W; i++) begin
      case (op)
        4'd0: s[i] = (i + c < W) ? v[i + c] : 1'b0;
        4'd1: s[i] = (i >= c) ? v[i - c] : 1'b0;
        4'd2: s[i] = v[(i + c) % W];
        4'd3: s[i] = v[(i - c + W) % W];
        4'd4: s[i] = (i + c < W) ? v[i + c] : v[W-1];
        default: s[i] = v[i];
      endcase
    end
    case (op)
      4'd8, 4'd12: jp = 1'b1;
      4'd9:  jp = (s[W-1] == 1'b1);
      4'd13: jp = (s[W-1] == 1'b0);
      4'd10: jp = ($countones(s) == 0);
      4'd14: jp = ($countones(s) != 0);
      4'd11: jp = cy;
      4'd15: jp = ~cy;
      default: jp = 1'b0;
    endcase
    return {s, cy, jp};
  endfunction

  task automatic check(input string req, input logic [W-1:0] er, input logic ec, input logic ej);
    n_checks++;
    if (result_o !== er || carry_o !== ec || jump_o !== ej) begin
      n_fail++;
      $display("FAIL %s: got res=%h c=%b j=%b expected res=%h c=%b j=%b (f=%0d op=%0d cnt=%0d a=%h b=%h)",
               req, result_o, carry_o, jump_o, er, ec, ej, func_i, op_i, count_i, opa_i, opb_i);
    end
  endtask

  task automatic drive(input logic [2:0] f, input logic [3:0] op, input logic [4:0] c,
                       input logic [W-1:0] a, input logic [W-1:0] b);
    @(negedge clk);
    func_i = f; op_i = op; count_i = c; opa_i = a; opb_i = b;
    @(negedge clk);
  endtask

  initial begin
    logic [W+1:0] r;
    logic [W-1:0] pa [6];
    logic [W-1:0] pb [6];
    logic [VW-1:0] e;

    repeat (3) @(negedge clk);
    check("R10 reset state", '0, 1'b0, 1'b0);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      e = VEC[i];
      drive(e[VW-1 -: 3], e[VW-4 -: 4], e[VW-8 -: 5], e[VW-13 -: 32], e[VW-45 -: 32]);
      check("R1-table", e[33:2], e[1], e[0]);
    end

    // sweep of all function x op x count on corner and random operands (R1 R2 R3 R4 R5 R6 R7 R8)
    pa[0] = 32'h0;        pb[0] = 32'h0;
    pa[1] = 32'hFFFFFFFF; pb[1] = 32'hFFFFFFFF;
    pa[2] = 32'h80000000; pb[2] = 32'h00000001;
    pa[3] = 32'h00000001; pb[3] = 32'h80000000;
    pa[4] = $urandom;     pb[4] = $urandom;
    pa[5] = $urandom;     pb[5] = pa[5];
    for (int p = 0; p < 6; p++)
      for (int f = 0; f < 8; f++)
        for (int op = 0; op < 16; op++)
          for (int c = 0; c < 32; c++) begin
            drive(3'(f), 4'(op), 5'(c), pa[p], pb[p]);
            r = ref_model(3'(f), 4'(op), 5'(c), pa[p], pb[p]);
            check("R3 R7 sweep", r[W+1:2], r[1], r[0]);
          end

    // R9: new inputs do not reach the outputs before the next edge
    drive(3'd0, 4'd5, 5'd0, 32'h00000010, 32'h00000020);
    @(negedge clk);
    func_i = 3'd4; op_i = 4'd8; opa_i = 32'hABCD0000; opb_i = 32'h0;
    #1;
    check("R9 hold before edge", 32'h00000030, 1'b0, 1'b0);
    @(negedge clk);
    check("R9 update after edge", 32'hABCD0000, 1'b0, 1'b1);

    // R10: reset mid-run clears nonzero outputs
    drive(3'd0, 4'd11, 5'd0, 32'hFFFFFFFF, 32'h00000002);
    check("R10 pre-reset value", 32'h00000001, 1'b1, 1'b1);
    rst = 1'b1;
    @(negedge clk);
    check("R10 reset clears", '0, 1'b0, 1'b0);
    rst = 1'b0;
    @(negedge clk);
    check("R9 resumes after reset", 32'h00000001, 1'b1, 1'b1);

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

endmodule